// File: doc/BRIEF.md
# Packed Pixel Unpacker with Palette

This block turns a stream of 32-bit frame-buffer words into a stream of 32-bit colour pixels, one pixel per clock when both sides are willing. A 3-bit depth code inside a display control word decides how many pixels each word carries and how each one is coloured. The four indexed depths (1, 2, 4 and 8 bits) look each pixel value up in a 256-entry colour table. The 15- and 16-bit direct depths widen their colour fields to 8 bits. The 32-bit depth passes the word through unchanged. One code blanks the output. A display-enable bit in the same control word forces every produced pixel to black. The interlace bit is passed straight to a status output.

The colour table is loaded through a simple register write port. Table slots occupy register addresses 0x100 to 0x1FF. Each entry is stored at the bit-reversed position of its slot number, because the pixel data is scanned in the opposite bit order. The control word is captured together with each memory word on acceptance, so a change of depth takes effect on a word boundary.

Back-pressure rules: `mem_ready` is high when the word holder is empty, or when its last pixel leaves in the current cycle. A word transfers on any rising edge where `mem_valid` and `mem_ready` are both high. While `pix_valid` is high and `pix_ready` is low, the output pixel holds its value. Pixels leave in the order of the words and, within a word, from the least significant end first.

Top module: `pix_unpack_top`

## Requirements
- R1: Depth code in control bits 22:20 sets the pixels per word. Codes 0, 1, 2 and 3 are 1, 2, 4 and 8 bpp indexed, giving 32, 16, 8 and 4 pixels. Codes 4 and 5 (15 and 16 bpp) give 2 pixels, each taken from a 16-bit slot. Codes 6 (32 bpp) and 7 give 1 pixel. Pixels are taken from bit 0 upward.
- R2: A register write to address 0x100+e stores its colour in table entry bit-reverse(e), where bit 0 swaps with bit 7, bit 1 with bit 6, and so on. An indexed pixel of value v reads entry v.
- R3: Table data holds red in bits 7:0, green in bits 15:8 and blue in bits 23:16. An indexed pixel outputs {8'h00, blue, green, red}. Write data bits 31:24 are dropped.
- R4: At code 6 the output pixel equals the memory word unchanged, with red in the low byte.
- R5: At code 4, red is bits 4:0, green is bits 9:5 and blue is bits 14:10 of the slot. Each 5-bit field x becomes (x<<3)|(x>>2), and bit 15 is ignored.
- R6: At code 5, red is bits 4:0, green is bits 10:5 and blue is bits 15:11. The 5-bit fields widen as in R5, and the 6-bit field x becomes (x<<2)|(x>>4).
- R7: Code 7 emits one black pixel (0) per word.
- R8: When control bit 0 is 0, every pixel of the word is 0, still at the pixel count set by the depth code.
- R9: `disp_interlace` equals control bit 1 as sampled at the previous rising edge.
- R10: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and `pix_data` is unchanged. No pixel is dropped or repeated.
- R11: A table write in the same cycle that a pixel looks up that entry gives the old colour to that pixel. Later pixels get the new colour.
- R12: After reset, `pix_valid` is 0 and `mem_ready` is 1.
- R13: Register writes to addresses outside 0x100 to 0x1FF leave the colour table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Display control word (bit 0 enable, bit 1 interlace, bits 22:20 depth) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register slot address |
| reg_wdata | input | 32 | Register write data |
| mem_valid | input | 1 | Memory word valid |
| mem_ready | output | 1 | Block can take a memory word |
| mem_data | input | 32 | Memory word |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Consumer takes the pixel |
| pix_data | output | 32 | Pixel {8'h00/alpha, blue, green, red} |
| disp_interlace | output | 1 | Registered interlace status |

## Verification
A wrong slot index or an off-by-one pixel count shifts every later pixel of the stream, so it shows as a mismatch on the first pixel after the faulty word boundary. A wrong palette index permutation shows as wrong colours on the first indexed pixel that uses an affected entry. The full sweep touches all 256 entries. A broken hold under back-pressure shows as a changed `pix_data` within one cycle of a stall.

// File: rtl/pixunp_pkg.sv
package pixunp_pkg;
  localparam int WORD_W = 32;
  localparam int PAL_AW = 8;
  localparam int PAL_N  = 1 << PAL_AW;

  localparam logic [2:0] DEPTH_1  = 3'd0;
  localparam logic [2:0] DEPTH_2  = 3'd1;
  localparam logic [2:0] DEPTH_4  = 3'd2;
  localparam logic [2:0] DEPTH_8  = 3'd3;
  localparam logic [2:0] DEPTH_15 = 3'd4;
  localparam logic [2:0] DEPTH_16 = 3'd5;
  localparam logic [2:0] DEPTH_32 = 3'd6;
  localparam logic [2:0] DEPTH_NONE = 3'd7;

  // width in bits of one pixel slot inside a memory word
  function automatic logic [5:0] slot_bits(input logic [2:0] code);
    case (code)
      DEPTH_1:  slot_bits = 6'd1;
      DEPTH_2:  slot_bits = 6'd2;
      DEPTH_4:  slot_bits = 6'd4;
      DEPTH_8:  slot_bits = 6'd8;
      DEPTH_15, DEPTH_16: slot_bits = 6'd16;
      default:  slot_bits = 6'd32;
    endcase
  endfunction

  function automatic logic [5:0] slot_count(input logic [2:0] code);
    case (code)
      DEPTH_1:  slot_count = 6'd32;
      DEPTH_2:  slot_count = 6'd16;
      DEPTH_4:  slot_count = 6'd8;
      DEPTH_8:  slot_count = 6'd4;
      DEPTH_15, DEPTH_16: slot_count = 6'd2;
      default:  slot_count = 6'd1;
    endcase
  endfunction

  function automatic logic [PAL_AW-1:0] bit_flip(input logic [PAL_AW-1:0] v);
    for (int i = 0; i < PAL_AW; i++) bit_flip[i] = v[PAL_AW-1-i];
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] x);
    widen5 = {x, x[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] x);
    widen6 = {x, x[5:4]};
  endfunction
endpackage

// File: rtl/pixunp_palette.sv
module pixunp_palette
  import pixunp_pkg::*;
#(
  parameter int REG_AW   = 10,
  parameter int PAL_BASE = 'h100
) (
  input  logic              clk,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [23:0]       wdata,
  input  logic [PAL_AW-1:0] ridx,
  output logic [23:0]       rdata
);
  localparam int HI_W = REG_AW - PAL_AW;
  localparam logic [HI_W-1:0] BASE_HI = HI_W'(PAL_BASE >> PAL_AW);

  logic [23:0] table_q [PAL_N];
  logic        hit;

  assign hit   = we && (waddr[REG_AW-1:PAL_AW] == BASE_HI);
  assign rdata = table_q[ridx];

  always_ff @(posedge clk) begin
    if (hit) table_q[bit_flip(waddr[PAL_AW-1:0])] <= wdata;
  end
endmodule

// File: rtl/pixunp_slicer.sv
module pixunp_slicer
  import pixunp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [2:0]        in_code,
  input  logic              in_en,
  input  logic              adv,
  output logic              full,
  output logic [WORD_W-1:0] word,
  output logic [2:0]        code,
  output logic              en,
  output logic [WORD_W-1:0] field
);
  logic [4:0] idx_q;
  logic [5:0] shamt;
  logic       last;

  assign last     = ({1'b0, idx_q} == (slot_count(code) - 6'd1));
  assign in_ready = !full || (adv && last);
  assign shamt    = 6'(idx_q) * slot_bits(code);
  assign field    = word >> shamt[4:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full  <= 1'b0;
      idx_q <= '0;
      word  <= '0;
      code  <= DEPTH_NONE;
      en    <= 1'b0;
    end else if (in_valid && in_ready) begin
      full  <= 1'b1;
      idx_q <= '0;
      word  <= in_word;
      code  <= in_code;
      en    <= in_en;
    end else if (adv) begin
      if (last) full <= 1'b0;
      else      idx_q <= idx_q + 5'd1;
    end
  end
endmodule

// File: rtl/pixunp_colour.sv
module pixunp_colour
  import pixunp_pkg::*;
(
  input  logic [WORD_W-1:0] field,
  input  logic [2:0]        code,
  input  logic              en,
  output logic [PAL_AW-1:0] pal_idx,
  input  logic [23:0]       pal_rgb,
  output logic [WORD_W-1:0] pixel
);
  logic [7:0] idx_mask;

  always_comb begin
    case (code)
      DEPTH_1: idx_mask = 8'h01;
      DEPTH_2: idx_mask = 8'h03;
      DEPTH_4: idx_mask = 8'h0F;
      default: idx_mask = 8'hFF;
    endcase
    pal_idx = field[7:0] & idx_mask;

    case (code)
      DEPTH_1, DEPTH_2, DEPTH_4, DEPTH_8: pixel = {8'h00, pal_rgb};
      DEPTH_15: pixel = {8'h00, widen5(field[14:10]), widen5(field[9:5]), widen5(field[4:0])};
      DEPTH_16: pixel = {8'h00, widen5(field[15:11]), widen6(field[10:5]), widen5(field[4:0])};
      DEPTH_32: pixel = field;
      default:  pixel = '0;
    endcase
    if (!en) pixel = '0;
  end
endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
  import pixunp_pkg::*;
#(
  parameter int REG_AW   = 10,
  parameter int PAL_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctrl_word,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              mem_valid,
  output logic              mem_ready,
  input  logic [31:0]       mem_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [31:0]       pix_data,
  output logic              disp_interlace
);
  logic              adv;
  logic              hold_full;
  logic [WORD_W-1:0] hold_word;
  logic [2:0]        hold_code;
  logic              hold_en;
  logic [WORD_W-1:0] hold_field;
  logic [PAL_AW-1:0] pal_idx;
  logic [23:0]       pal_rgb;
  logic [WORD_W-1:0] fmt_pixel;

  assign adv = hold_full && (!pix_valid || pix_ready);

  pixunp_slicer u_slicer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (mem_valid),
    .in_ready (mem_ready),
    .in_word  (mem_data),
    .in_code  (ctrl_word[22:20]),
    .in_en    (ctrl_word[0]),
    .adv      (adv),
    .full     (hold_full),
    .word     (hold_word),
    .code     (hold_code),
    .en       (hold_en),
    .field    (hold_field)
  );

  pixunp_palette #(.REG_AW(REG_AW), .PAL_BASE(PAL_BASE)) u_palette (
    .clk   (clk),
    .we    (reg_we),
    .waddr (reg_addr),
    .wdata (reg_wdata[23:0]),
    .ridx  (pal_idx),
    .rdata (pal_rgb)
  );

  pixunp_colour u_colour (
    .field   (hold_field),
    .code    (hold_code),
    .en      (hold_en),
    .pal_idx (pal_idx),
    .pal_rgb (pal_rgb),
    .pixel   (fmt_pixel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid      <= 1'b0;
      pix_data       <= '0;
      disp_interlace <= 1'b0;
    end else begin
      disp_interlace <= ctrl_word[1];
      if (adv) begin
        pix_valid <= 1'b1;
        pix_data  <= fmt_pixel;
      end else if (pix_ready) begin
        pix_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pixunp_checker.sv
module pixunp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_word,
  input logic        mem_ready,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic [31:0] pix_data,
  input logic        disp_interlace,
  input logic        adv,
  input logic        hold_full,
  input logic [31:0] hold_word,
  input logic [2:0]  hold_code,
  input logic        hold_en
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_data)); // R10
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready && hold_full |-> !mem_ready); // R10
  AST_WIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    adv && hold_en && hold_code == 3'd6 |=> pix_data == $past(hold_word)); // R4
  AST_NONE_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    adv && hold_code == 3'd7 |=> pix_data == 32'd0); // R7
  AST_OFF_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !hold_en |=> pix_data == 32'd0); // R8
  AST_LACE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> disp_interlace == $past(ctrl_word[1])); // R9
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_full |-> mem_ready); // R12
endmodule

bind pix_unpack_top pixunp_checker i_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .mem_ready(mem_ready),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
  .disp_interlace(disp_interlace), .adv(adv), .hold_full(hold_full),
  .hold_word(hold_word), .hold_code(hold_code), .hold_en(hold_en)
);

// File: tb/test_pix_unpack_top.sv
module test_pix_unpack_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        reg_we = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_valid = 1'b0;
  logic        mem_ready;
  logic [31:0] mem_data = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [31:0] pix_data;
  logic        disp_interlace;

  int checks = 0;
  int errors = 0;
  logic [31:0] expq[$];
  string       tagq[$];
  logic [23:0] shadow [256];
  logic        mon_en = 1'b0;
  logic        force_on = 1'b1;
  logic        force_val = 1'b0;
  logic [7:0]  lfsr = 8'hA1;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_pix = '0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_unpack_top i_pix_unpack_top (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_data(mem_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .disp_interlace(disp_interlace)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] brev(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic int bits_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd4, 3'd5: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [7:0] up5(input int x);
    return 8'((x << 3) | (x >> 2));
  endfunction
  function automatic logic [7:0] up6(input int x);
    return 8'((x << 2) | (x >> 4));
  endfunction

  function automatic logic [31:0] model(input logic [2:0] c, input logic en,
                                        input logic [31:0] w, input int k);
    int b = bits_of(c);
    logic [31:0] f = w >> (k * b);
    int s = int'(f[15:0]);
    if (!en || c == 3'd7) return 32'd0;
    if (c <= 3'd3) return {8'h00, shadow[brev(8'(f & ((32'd1 << b) - 1)))]};
    if (c == 3'd4) return {8'h00, up5((s >> 10) & 31), up5((s >> 5) & 31), up5(s & 31)};
    if (c == 3'd5) return {8'h00, up5((s >> 11) & 31), up6((s >> 5) & 63), up5(s & 31)};
    return w;
  endfunction

  function automatic string tag_of(input logic [2:0] c, input logic en);
    if (!en) return "R8";
    case (c)
      3'd0, 3'd1, 3'd2: return "R1";
      3'd3: return "R2";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R4";
      default: return "R7";
    endcase
  endfunction

  // output back-pressure pattern, changed just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    pix_ready = force_on ? force_val : (lfsr[0] | lfsr[2]);
  end

  // monitor: stall stability and ordered comparison
  initial forever begin
    @(negedge clk);
    if (mon_en && rst_n) begin
      if (prev_stall) begin
        check("R10 valid held", {31'd0, pix_valid}, 32'd1);
        check("R10 data held", pix_data, prev_pix);
      end
      prev_stall = pix_valid && !pix_ready;
      prev_pix   = pix_data;
      if (pix_valid && pix_ready) begin
        if (expq.size() == 0) check("R10 extra pixel", pix_data, 32'hDEADDEAD);
        else check(tagq.pop_front(), pix_data, expq.pop_front());
      end
    end else prev_stall = 1'b0;
  end

  task automatic reg_write(input logic [9:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (a[9:8] == 2'b01) shadow[a[7:0]] = d[23:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(input logic [2:0] c, input logic en, input logic [31:0] w);
    ctrl_word = {9'd0, c, 19'd0, en};
    mem_data  = w;
    mem_valid = 1'b1;
    while (!mem_ready) @(negedge clk);
    for (int k = 0; k < 32 / bits_of(c); k++) begin
      expq.push_back(model(c, en, w, k));
      tagq.push_back(tag_of(c, en));
    end
    @(negedge clk);
    mem_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0 || pix_valid) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 pix_valid after reset", {31'd0, pix_valid}, 32'd0);
    check("R12 mem_ready after reset", {31'd0, mem_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: interlace status one cycle late
    ctrl_word = 32'h2;
    @(negedge clk);
    check("R9 interlace high", {31'd0, disp_interlace}, 32'd1);
    ctrl_word = 32'h0;
    @(negedge clk);
    check("R9 interlace low", {31'd0, disp_interlace}, 32'd0);

    // load full table; upper byte must be dropped (R3)
    for (int e = 0; e < 256; e++)
      reg_write(10'h100 + 10'(e),
                {8'hEE, 8'(~e), 8'(e * 7 + 3), 8'(e ^ 'hA5)});

    force_on = 1'b0;
    mon_en = 1'b1;
    for (int c = 0; c < 8; c++)
      for (int n = 0; n < 12; n++)
        send(3'(c), 1'b1, 32'h9E3779B9 * (n + 1) + 32'(c * 32'h01010101));
    // every 8-bit value once: 64 words cover all entries (R2, R3)
    for (int n = 0; n < 64; n++)
      send(3'd3, 1'b1, {8'(4*n+3), 8'(4*n+2), 8'(4*n+1), 8'(4*n)});
    for (int c = 0; c < 8; c++) send(3'(c), 1'b0, 32'hFFFF_FFFF);
    drain();

    // R13: writes outside the table window
    reg_write(10'h010, 32'h0);
    reg_write(10'h210, 32'h0);
    reg_write(10'h3F0, 32'h0);
    send(3'd3, 1'b1, 32'h0F_08_0F_08);
    drain();
    check("R13 table untouched", {8'h00, shadow[8'h10]}, {8'h00, 8'(~8'h10), 8'(8'h10 * 7 + 3), 8'(8'h10 ^ 8'hA5)});

    // R11: write colliding with lookup of the same entry
    mon_en = 1'b0;
    force_on = 1'b1; force_val = 1'b0;
    repeat (2) @(negedge clk);
    reg_write(10'h100 + 10'(brev(8'h3C)), 32'h00112233);
    send(3'd3, 1'b1, 32'h3C3C3C3C);
    @(negedge clk);
    check("R11 first pixel old", pix_data, 32'h00112233);
    force_val = 1'b1;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 10'h100 + 10'(brev(8'h3C)); reg_wdata = 32'h00445566;
    @(negedge clk);
    reg_we = 1'b0;
    check("R11 colliding pixel old", pix_data, 32'h00112233);
    @(negedge clk);
    check("R11 next pixel new", pix_data, 32'h00445566);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule